// File: doc/BRIEF.md
# Compact Fetch Packet Instruction Unpacker

The unpacker takes one 256-bit fetch packet, made of eight 32-bit words in little-endian word order, and splits it into its individual instructions. It first checks the top nibble of the last word. If that nibble marks a header, the last word describes the other seven words. Each of those seven words then holds either one 32-bit instruction or a pair of 16-bit instructions, and the parallel-execution bits of the 16-bit slots sit in the header instead of in the instructions. If there is no header, the packet is eight plain 32-bit instructions.

Instructions leave one per cycle on a valid/ready stream, in ascending byte offset. Each one carries its width, its byte offset and an end-of-execute-packet flag. A chain flag reports whether the instruction runs in parallel with the instruction emitted before it, and this holds across packet boundaries too. The header attributes of the packet are held on registered outputs while its instructions are emitted. Only one packet is in the block at a time: the input accepts a new packet only once the last instruction of the current one has been taken.

Top module: `fp_unpacker`

## Requirements
- R1: A packet is header-based exactly when bits 255:252 (bits 31:28 of word 7) equal 4'hE; hdr_based shows this from the cycle after acceptance.
- R2: In a packet without a header, all eight words are emitted as 32-bit instructions (out_wide=1) at byte offsets 0,4,...,28, and every 32-bit instruction has an offset that is a multiple of 4.
- R3: In a header-based packet, header bit 21+k set makes word k (k=0..6) a compact word. Its bits 15:0 are emitted first at offset 4k, and its bits 31:16 are emitted next at offset 4k+2. Both have out_wide=0 and the halfword placed in out_insn[15:0] with bits 31:16 zero.
- R4: In a header-based packet the header word is never emitted, so every offset is below 28.
- R5: The registered header outputs show header bit 20 (hdr_prot), bit 19 (hdr_regset), bits 18:16 (hdr_dsize), bit 15 (hdr_branch) and bit 14 (hdr_sat) from the cycle after acceptance. All of them are zero for a packet without a header.
- R6: A 16-bit instruction at byte offset b takes header bit b/2 as its parallel bit, and out_eop is the inverse of that bit.
- R7: A 32-bit instruction takes its own bit 0 as its parallel bit, and out_eop is the inverse of that bit.
- R8: out_chain equals the parallel bit of the previously accepted instruction, including the last instruction of the previous packet.
- R9: Instructions are emitted in strictly ascending offset order, at most one per cycle. An instruction that is offered but not accepted stays unchanged.
- R10: in_ready is high only when no instruction is pending, and it is never high while out_valid is high. It rises in the cycle after the last instruction has been accepted.
- R11: An active-low reset drops out_valid, raises in_ready and clears the chain state, so the first instruction after reset has out_chain=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Fetch packet offered |
| in_ready | output | 1 | Block idle, packet accepted when in_valid is high |
| in_pkt | input | 256 | Fetch packet, word k in bits 32k+31:32k |
| out_valid | output | 1 | Instruction offered |
| out_ready | input | 1 | Consumer takes the instruction |
| out_insn | output | 32 | Instruction, 16-bit ones zero-extended |
| out_wide | output | 1 | 1 for a 32-bit instruction, 0 for a 16-bit one |
| out_offset | output | 5 | Byte offset within the packet |
| out_eop | output | 1 | Last instruction of its execute packet |
| out_chain | output | 1 | Runs in parallel with the previous instruction |
| hdr_based | output | 1 | Current packet has a header |
| hdr_prot | output | 1 | Protected-load attribute |
| hdr_regset | output | 1 | Register-set attribute |
| hdr_dsize | output | 3 | Data-size field |
| hdr_branch | output | 1 | Branch attribute |
| hdr_sat | output | 1 | Saturation attribute |

## Verification
The bench aims at the slot walk in packets that mix compact and full words. A pointer that steps by the wrong amount after a compact word would repeat or skip halfwords, or misalign the next 32-bit word. It checks that the header word stays hidden and that packets whose top nibble is close to 4'hE are treated as plain. A wrong decode would either swallow word 7 or split data words into halves. It also stalls the consumer and checks that the offered instruction does not move. Finally, it sends the last instruction of a packet with its parallel bit set and checks the chain flag of the next packet, which a design that clears the chain state on every new packet would get wrong.

// File: rtl/fp_unpack_pkg.sv
package fp_unpack_pkg;

  localparam int unsigned FP_WORDS   = 8;
  localparam int unsigned FP_WORD_W  = 32;
  localparam int unsigned FP_HALF_W  = FP_WORD_W / 2;
  localparam int unsigned FP_PKT_W   = FP_WORDS * FP_WORD_W;
  localparam int unsigned FP_CMP_N   = FP_WORDS - 1;
  localparam int unsigned FP_PBIT_N  = 2 * FP_CMP_N;
  localparam int unsigned FP_SLOTS   = 2 * FP_WORDS;
  localparam int unsigned FP_PTR_W   = $clog2(FP_SLOTS) + 1;
  localparam int unsigned FP_OFF_W   = $clog2(FP_WORDS * 4);
  localparam int unsigned FP_DSZ_W   = 3;

  localparam logic [3:0] FP_HDR_TAG  = 4'hE;

  localparam int unsigned FP_POS_CMP  = 21;
  localparam int unsigned FP_POS_PROT = 20;
  localparam int unsigned FP_POS_RS   = 19;
  localparam int unsigned FP_POS_DSZ  = 16;
  localparam int unsigned FP_POS_BR   = 15;
  localparam int unsigned FP_POS_SAT  = 14;

  typedef struct packed {
    logic                   based;
    logic [FP_CMP_N-1:0]    compact;
    logic                   prot;
    logic                   regset;
    logic [FP_DSZ_W-1:0]    dsize;
    logic                   branch;
    logic                   sat;
    logic [FP_PBIT_N-1:0]   pbits;
  } fp_hdr_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_EMIT = 1'b1
  } fp_state_e;

endpackage

// File: rtl/fp_hdr_decode.sv
module fp_hdr_decode
  import fp_unpack_pkg::*;
(
  input  logic [FP_WORD_W-1:0] tail_word,
  output fp_hdr_t              hdr
);

  logic is_hdr;

  assign is_hdr = (tail_word[FP_WORD_W-1 -: 4] == FP_HDR_TAG);

  always_comb begin
    hdr         = '0;
    hdr.based   = is_hdr;
    if (is_hdr) begin
      hdr.compact = tail_word[FP_POS_CMP +: FP_CMP_N];
      hdr.prot    = tail_word[FP_POS_PROT];
      hdr.regset  = tail_word[FP_POS_RS];
      hdr.dsize   = tail_word[FP_POS_DSZ +: FP_DSZ_W];
      hdr.branch  = tail_word[FP_POS_BR];
      hdr.sat     = tail_word[FP_POS_SAT];
      hdr.pbits   = tail_word[0 +: FP_PBIT_N];
    end
  end

endmodule

// File: rtl/fp_slot_select.sv
module fp_slot_select
  import fp_unpack_pkg::*;
(
  input  logic [FP_PKT_W-1:0]  pkt,
  input  fp_hdr_t              hdr,
  input  logic [FP_PTR_W-1:0]  hptr,
  output logic [FP_WORD_W-1:0] insn,
  output logic                 wide,
  output logic                 par,
  output logic [FP_PTR_W-1:0]  next_ptr,
  output logic                 last
);

  localparam int unsigned WIDX_W = $clog2(FP_WORDS);
  localparam int unsigned HIDX_W = $clog2(FP_SLOTS);

  logic [FP_WORD_W-1:0] words [FP_WORDS];
  logic [FP_WORDS-1:0]  cmp_vec;
  logic [FP_SLOTS-1:0]  pbit_vec;
  logic [WIDX_W-1:0]    widx;
  logic [HIDX_W-1:0]    hidx;
  logic [FP_WORD_W-1:0] cur_word;
  logic                 is_cmp;
  logic [FP_PTR_W-1:0]  limit;

  genvar g;
  generate
    for (g = 0; g < FP_WORDS; g++) begin : g_word
      assign words[g] = pkt[g*FP_WORD_W +: FP_WORD_W];
    end
  endgenerate

  assign cmp_vec  = {1'b0, hdr.compact};
  assign pbit_vec = {2'b00, hdr.pbits};
  assign hidx     = hptr[HIDX_W-1:0];
  assign widx     = hidx[HIDX_W-1:1];
  assign cur_word = words[widx];
  assign is_cmp   = hdr.based & cmp_vec[widx];

  always_comb begin
    if (is_cmp) begin
      insn = {{FP_HALF_W{1'b0}},
              (hidx[0] ? cur_word[FP_WORD_W-1:FP_HALF_W] : cur_word[FP_HALF_W-1:0])};
      par  = pbit_vec[hidx];
    end else begin
      insn = cur_word;
      par  = cur_word[0];
    end
  end

  assign wide     = ~is_cmp;
  assign next_ptr = hptr + (is_cmp ? FP_PTR_W'(1) : FP_PTR_W'(2));
  assign limit    = hdr.based ? FP_PTR_W'(FP_PBIT_N) : FP_PTR_W'(FP_SLOTS);
  assign last     = (next_ptr >= limit);

endmodule

// File: rtl/fp_unpacker.sv
module fp_unpacker
  import fp_unpack_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [FP_PKT_W-1:0]  in_pkt,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [FP_WORD_W-1:0] out_insn,
  output logic                 out_wide,
  output logic [FP_OFF_W-1:0]  out_offset,
  output logic                 out_eop,
  output logic                 out_chain,
  output logic                 hdr_based,
  output logic                 hdr_prot,
  output logic                 hdr_regset,
  output logic [FP_DSZ_W-1:0]  hdr_dsize,
  output logic                 hdr_branch,
  output logic                 hdr_sat
);

  fp_state_e           state_q, state_d;
  logic [FP_PKT_W-1:0] pkt_q;
  fp_hdr_t             hdr_q, hdr_in;
  logic [FP_PTR_W-1:0] hptr_q, hptr_d;
  logic                chain_q, chain_d;

  logic                pkt_load;
  logic                slot_adv;
  logic                slot_par;
  logic                slot_last;
  logic [FP_PTR_W-1:0] slot_next;

  fp_hdr_decode u_hdr (
    .tail_word (in_pkt[FP_PKT_W-1 -: FP_WORD_W]),
    .hdr       (hdr_in)
  );

  fp_slot_select u_sel (
    .pkt      (pkt_q),
    .hdr      (hdr_q),
    .hptr     (hptr_q),
    .insn     (out_insn),
    .wide     (out_wide),
    .par      (slot_par),
    .next_ptr (slot_next),
    .last     (slot_last)
  );

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_EMIT);
  assign pkt_load  = in_valid & in_ready;
  assign slot_adv  = out_valid & out_ready;

  always_comb begin
    state_d = state_q;
    hptr_d  = hptr_q;
    chain_d = chain_q;
    if (pkt_load) begin
      state_d = ST_EMIT;
      hptr_d  = '0;
    end else if (slot_adv) begin
      chain_d = slot_par;
      hptr_d  = slot_next;
      if (slot_last) begin
        state_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hptr_q  <= '0;
      chain_q <= 1'b0;
      hdr_q   <= '0;
    end else begin
      state_q <= state_d;
      hptr_q  <= hptr_d;
      chain_q <= chain_d;
      if (pkt_load) begin
        hdr_q <= hdr_in;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pkt_load) begin
      pkt_q <= in_pkt;
    end
  end

  assign out_offset = {hptr_q[FP_OFF_W-2:0], 1'b0};
  assign out_eop    = ~slot_par;
  assign out_chain  = chain_q;

  assign hdr_based  = hdr_q.based;
  assign hdr_prot   = hdr_q.prot;
  assign hdr_regset = hdr_q.regset;
  assign hdr_dsize  = hdr_q.dsize;
  assign hdr_branch = hdr_q.branch;
  assign hdr_sat    = hdr_q.sat;

  AST_HS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R10

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_insn) && $stable(out_offset))); // R9

  AST_OFFSET_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !slot_last) |=> (out_valid && (out_offset > $past(out_offset)))); // R9

  AST_LAST_FREES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && slot_last) |=> in_ready); // R10

  AST_NARROW_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_wide) |-> (out_insn[FP_WORD_W-1:FP_HALF_W] == '0)); // R3

  AST_WIDE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_wide) |-> (out_offset[1:0] == 2'b00)); // R2

  AST_HEADER_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && hdr_based) |-> (out_offset < FP_OFF_W'(28))); // R4

  AST_CHAIN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (out_chain == !$past(out_eop))); // R8

endmodule

// File: tb/fp_unpacker_test.sv
`timescale 1ns/1ps
module fp_unpacker_test;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [255:0] in_pkt;
  logic         out_valid;
  logic         out_ready;
  logic [31:0]  out_insn;
  logic         out_wide;
  logic [4:0]   out_offset;
  logic         out_eop;
  logic         out_chain;
  logic         hdr_based;
  logic         hdr_prot;
  logic         hdr_regset;
  logic [2:0]   hdr_dsize;
  logic         hdr_branch;
  logic         hdr_sat;

  int total;
  int bad;

  logic [31:0] e_insn [16];
  bit          e_wide [16];
  int          e_off  [16];
  bit          e_par  [16];
  int          e_n;
  bit          m_chain;
  logic [31:0] lcg;

  fp_unpacker uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_pkt(in_pkt),
    .out_valid(out_valid), .out_ready(out_ready), .out_insn(out_insn),
    .out_wide(out_wide), .out_offset(out_offset), .out_eop(out_eop),
    .out_chain(out_chain), .hdr_based(hdr_based), .hdr_prot(hdr_prot),
    .hdr_regset(hdr_regset), .hdr_dsize(hdr_dsize), .hdr_branch(hdr_branch),
    .hdr_sat(hdr_sat)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] next_rand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  function automatic logic [255:0] fill_words();
    logic [255:0] p;
    for (int w = 0; w < 8; w++) p[32*w +: 32] = next_rand();
    return p;
  endfunction

  task automatic build_exp(input logic [255:0] p);
    logic [31:0] hw;
    bit based;
    int top;
    hw    = p[255:224];
    based = (hw[31:28] == 4'hE);
    top   = based ? 7 : 8;
    e_n   = 0;
    for (int w = 0; w < top; w++) begin
      logic [31:0] wd;
      wd = p[32*w +: 32];
      if (based && hw[21+w]) begin
        e_insn[e_n] = {16'h0, wd[15:0]};  e_wide[e_n] = 0; e_off[e_n] = 4*w;   e_par[e_n] = hw[2*w];   e_n++;
        e_insn[e_n] = {16'h0, wd[31:16]}; e_wide[e_n] = 0; e_off[e_n] = 4*w+2; e_par[e_n] = hw[2*w+1]; e_n++;
      end else begin
        e_insn[e_n] = wd; e_wide[e_n] = 1; e_off[e_n] = 4*w; e_par[e_n] = wd[0]; e_n++;
      end
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    out_ready = 1'b0;
    m_chain = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11 out_valid in reset", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R11 in_ready in reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Offers a packet at a negedge; it is taken at the next posedge and the
  // task returns at the following negedge, when outputs are registered.
  task automatic send(input logic [255:0] p);
    logic [31:0] hw;
    hw = p[255:224];
    build_exp(p);
    chk(in_ready == 1'b1, "R10 idle before packet", 32'(in_ready), 32'd1);
    in_pkt = p;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    in_pkt = '0;
    if (hw[31:28] == 4'hE) begin
      chk(hdr_based == 1'b1, "R1 header detect", 32'(hdr_based), 32'd1);
      chk({hdr_prot, hdr_regset, hdr_dsize, hdr_branch, hdr_sat} == hw[20:14],
          "R5 header attributes", 32'({hdr_prot, hdr_regset, hdr_dsize, hdr_branch, hdr_sat}), 32'(hw[20:14]));
    end else begin
      chk(hdr_based == 1'b0, "R1 plain detect", 32'(hdr_based), 32'd0);
      chk({hdr_prot, hdr_regset, hdr_dsize, hdr_branch, hdr_sat} == 7'd0,
          "R5 attributes zero when plain", 32'({hdr_prot, hdr_regset, hdr_dsize, hdr_branch, hdr_sat}), 32'd0);
    end
  endtask

  task automatic drain(input bit stall);
    int idx;
    int cyc;
    idx = 0;
    cyc = 0;
    while (idx < e_n) begin
      if (!out_valid) begin
        chk(1'b0, "R9 instruction expected", 32'(out_valid), 32'd1);
        idx = e_n;
      end else begin
        chk(out_insn == e_insn[idx], e_wide[idx] ? "R2 wide data" : "R3 halfword data", out_insn, e_insn[idx]);
        chk(out_wide == e_wide[idx], e_wide[idx] ? "R2 width flag" : "R3 width flag", 32'(out_wide), 32'(e_wide[idx]));
        chk(out_offset == 5'(e_off[idx]), "R9 offset order", 32'(out_offset), 32'(e_off[idx]));
        chk(out_eop == !e_par[idx], e_wide[idx] ? "R7 eop from bit0" : "R6 eop from header", 32'(out_eop), 32'(!e_par[idx]));
        chk(out_chain == m_chain, "R8 chain flag", 32'(out_chain), 32'(m_chain));
        chk(in_ready == 1'b0, "R10 busy while emitting", 32'(in_ready), 32'd0);
        out_ready = stall ? ((cyc % 3) == 2) : 1'b1;
        if (out_ready) begin
          m_chain = e_par[idx];
          idx++;
        end
        cyc++;
        @(negedge clk);
      end
    end
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R10 no output after last", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R10 ready after last", 32'(in_ready), 32'd1);
  endtask

  task automatic t_reset_state();
    chk(in_ready == 1'b1, "R11 in_ready after reset", 32'(in_ready), 32'd1);
    chk(out_valid == 1'b0, "R11 out_valid after reset", 32'(out_valid), 32'd0);
  endtask

  task automatic t_plain();
    logic [255:0] p;
    p = fill_words();
    p[255:252] = 4'h3;
    p[0] = 1'b1;
    p[32] = 1'b0;
    send(p);
    chk(e_n == 8, "R2 eight slots", 32'(e_n), 32'd8);
    drain(1'b0);
  endtask

  task automatic t_all_compact();
    logic [255:0] p;
    p = fill_words();
    p[255:224] = {4'hE, 7'h7F, 1'b1, 1'b0, 3'b101, 1'b1, 1'b0, 14'h2A5B};
    send(p);
    chk(e_n == 14, "R4 fourteen halfwords", 32'(e_n), 32'd14);
    drain(1'b0);
  endtask

  task automatic t_mixed_stall();
    logic [255:0] p;
    p = fill_words();
    p[255:224] = {4'hE, 7'b1010010, 1'b0, 1'b1, 3'b010, 1'b0, 1'b1, 14'h1C36};
    send(p);
    drain(1'b1);
  endtask

  task automatic t_header_no_compact();
    logic [255:0] p;
    p = fill_words();
    p[255:224] = {4'hE, 7'h00, 7'b1111111, 14'h3FFF};
    send(p);
    chk(e_n == 7, "R4 seven wide words", 32'(e_n), 32'd7);
    drain(1'b0);
  endtask

  task automatic t_near_tags();
    logic [255:0] p;
    p = fill_words();
    p[255:252] = 4'hF;
    send(p);
    drain(1'b0);
    p = fill_words();
    p[255:252] = 4'h6;
    send(p);
    drain(1'b1);
  endtask

  task automatic t_cross_chain();
    logic [255:0] p;
    p = fill_words();
    p[255:252] = 4'h1;
    p[224] = 1'b1;
    send(p);
    drain(1'b0);
    chk(m_chain == 1'b1, "R8 open packet carried", 32'(m_chain), 32'd1);
    p = fill_words();
    p[255:224] = {4'hE, 7'b1000001, 7'b0000000, 14'h2001};
    send(p);
    drain(1'b0);
    p = fill_words();
    p[255:252] = 4'h0;
    send(p);
    drain(1'b0);
  endtask

  task automatic t_reset_midway();
    logic [255:0] p;
    p = fill_words();
    p[255:252] = 4'h2;
    p[0] = 1'b1;
    send(p);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    apply_reset();
    t_reset_state();
    p = fill_words();
    p[255:252] = 4'h5;
    send(p);
    chk(out_chain == 1'b0, "R11 chain cleared by reset", 32'(out_chain), 32'd0);
    drain(1'b0);
  endtask

  initial begin
    total = 0;
    bad = 0;
    lcg = 32'h1234_5678;
    rst_n = 1'b0;
    in_valid = 1'b0;
    out_ready = 1'b0;
    in_pkt = '0;
    m_chain = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_plain();
    t_all_compact();
    t_mixed_stall();
    t_header_no_compact();
    t_near_tags();
    t_cross_chain();
    t_reset_midway();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule